// File: doc/BRIEF.md
# Global-Shutter Frame Timing Sequencer

This block produces the frame and line timing for a global-shutter pixel array. An enable pulse, one input-clock cycle in four, marks a core tick, and every phase and index of the sequencer moves only on such a tick. Each frame begins with a frame-overhead phase. Lines then follow one at a time. A line opens with a row-overhead phase and then selects pixel kernels one per tick, from index 0 up to the last kernel.

A line counter tracks the lines read out. Four 12-bit targets are compared against it, and each holds its line number minus one, so an event fires as the last kernel of the selected line finishes. The first target releases the pixel reset, which starts integration. The second and third targets each fire a reset pulse, one for dual slope and one for triple slope. The fourth target ends the frame readout. At that point it fires the frame-transfer pulse and restarts the frame-overhead phase. Integration of the next frame therefore runs while the current frame is read out.

A 2-bit granularity code sets the width of every pulse. In slave mode three external pins drive the pixel reset and the two slope pulses directly. The readout sequence and the transfer pulse stay internal in both modes. All targets and mode bits are plain parallel inputs with no handshake.

Top module: `pix_frame_seq`

## Requirements
- R1: The readout state (phase flags, kernel index, line index) changes only on every fourth input-clock edge. After reset is released, the first change happens on the fourth edge.
- R2: While reset is held, the outputs are: frame-overhead flag 1, row-overhead flag 0, kernel index 0, line index 0, pixel reset 1, and the dual-slope, triple-slope and transfer pulses all 0.
- R3: A frame-overhead phase lasts FRAME_OVH ticks. Each line then has ROW_OVH ticks of row overhead (row flag 1), followed by KERNELS ticks in which both flags are 0 and the kernel index counts 0, 1, … KERNELS-1, one step per tick. The line index starts at 0 and steps by one per line.
- R4: The last line of a frame is the lower of the transfer target and LINES-1. When its last kernel ends, the frame-overhead phase starts again, the line index returns to 0 and the transfer pulse rises on the same edge.
- R5: A target value n fires its event on the edge that ends kernel KERNELS-1 of line n. A target above the frame's last line never fires.
- R6: Every pulse stays high for 4*(12*(G+1)+1) input-clock cycles. G is the 2-bit granularity code, sampled on the edge that starts the pulse, so a later change of G does not alter a running pulse.
- R7: In master mode (slave_mode=0) the pixel reset output falls at the reset-release match and rises again at the frame end. When both fall on the same line, the frame end wins and pixel reset stays 1.
- R8: In master mode the dual-slope and triple-slope pulses start at their own target matches. Both may start on the same edge.
- R9: In slave mode (slave_mode=1), the pixel reset, dual-slope and triple-slope outputs equal ext_pix_rst, ext_dual and ext_triple as sampled one input clock earlier. Readout phases and the transfer pulse keep their master-mode timing.
- R10: The kernel index never exceeds KERNELS-1 and the line index never exceeds the frame's last line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| slave_mode | input | 1 | 1 = integration outputs follow the external pins |
| gran | input | 2 | Pulse width granularity code G |
| rel_line | input | 12 | Line (minus 1) that releases pixel reset |
| dual_line | input | 12 | Line (minus 1) that fires the dual-slope pulse |
| triple_line | input | 12 | Line (minus 1) that fires the triple-slope pulse |
| xfer_line | input | 12 | Line (minus 1) that ends readout and fires transfer |
| ext_pix_rst | input | 1 | Slave-mode pixel reset pin |
| ext_dual | input | 1 | Slave-mode dual-slope pin |
| ext_triple | input | 1 | Slave-mode triple-slope pin |
| ovh_frame | output | 1 | Frame-overhead phase active |
| ovh_row | output | 1 | Row-overhead phase active |
| kernel_idx | output | $clog2(KERNELS) | Selected pixel kernel |
| line_idx | output | $clog2(LINES) | Line being read |
| pix_rst | output | 1 | Pixel reset, 1 holds the photodiodes in reset |
| dual_pulse | output | 1 | Dual-slope reset pulse |
| triple_pulse | output | 1 | Triple-slope reset pulse |
| xfer_pulse | output | 1 | Frame-transfer pulse |

## Verification
Two pairs of functions can land on the same core tick. The frame end can coincide with the reset-release match, and the dual-slope pulse can coincide with the triple-slope pulse. The vector table places the release target on the last line of a frame, once where the transfer target cuts the frame short and once at the final line. In those cases the bench expects pixel reset never to fall, while the transfer pulse and the restart of the frame-overhead phase still occur on the predicted edge. Another vector puts the dual-slope and triple-slope targets on the same line. The bench then requires both pulses to start on the same edge with full width. A granularity change made right after the first pulse starts must leave that pulse's width unchanged and set the width of the pulses that follow.

// File: rtl/fs_pkg.sv
package fs_pkg;
  localparam int REG_W = 12;

  typedef enum logic [1:0] {
    PH_FRAME_OVH = 2'd0,
    PH_ROW_OVH   = 2'd1,
    PH_KERNELS   = 2'd2
  } phase_t;

  // Pulse width in input-clock cycles for granularity code g.
  function automatic int pulse_len(input logic [1:0] g);
    return 4 * (12 * (32'(g) + 1) + 1);
  endfunction

  localparam int PULSE_MAX = 4 * (12 * 4 + 1);
  localparam int PULSE_CW  = $clog2(PULSE_MAX + 1);
endpackage

// File: rtl/fs_clkdiv.sv
module fs_clkdiv #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/fs_readout.sv
module fs_readout import fs_pkg::*; #(
  parameter int LINES     = 480,
  parameter int KERNELS   = 160,
  parameter int ROW_OVH   = 16,
  parameter int FRAME_OVH = 16,
  localparam int LW = $clog2(LINES),
  localparam int KW = $clog2(KERNELS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [REG_W-1:0] xfer_line,
  output logic             ovh_frame,
  output logic             ovh_row,
  output logic [KW-1:0]    kernel_idx,
  output logic [LW-1:0]    line_idx,
  output logic             line_end,
  output logic             frame_end
);
  localparam int OVH_MAX = (ROW_OVH > FRAME_OVH) ? ROW_OVH : FRAME_OVH;
  localparam int OW      = $clog2(OVH_MAX + 1);

  phase_t        ph;
  logic [OW-1:0] ocnt;
  logic [KW-1:0] kern_q;
  logic [LW-1:0] line_q;
  logic          last_line;

  assign last_line = (REG_W'(line_q) == xfer_line) || (line_q == LW'(LINES - 1));
  assign line_end  = tick && (ph == PH_KERNELS) && (kern_q == KW'(KERNELS - 1));
  assign frame_end = line_end && last_line;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_FRAME_OVH;
      ocnt   <= '0;
      kern_q <= '0;
      line_q <= '0;
    end else if (tick) begin
      unique case (ph)
        PH_FRAME_OVH: begin
          if (ocnt == OW'(FRAME_OVH - 1)) begin
            ph     <= PH_ROW_OVH;
            ocnt   <= '0;
            line_q <= '0;
          end else begin
            ocnt <= ocnt + 1'b1;
          end
        end
        PH_ROW_OVH: begin
          if (ocnt == OW'(ROW_OVH - 1)) begin
            ph     <= PH_KERNELS;
            ocnt   <= '0;
            kern_q <= '0;
          end else begin
            ocnt <= ocnt + 1'b1;
          end
        end
        PH_KERNELS: begin
          if (kern_q == KW'(KERNELS - 1)) begin
            kern_q <= '0;
            if (last_line) begin
              ph     <= PH_FRAME_OVH;
              line_q <= '0;
            end else begin
              ph     <= PH_ROW_OVH;
              line_q <= line_q + 1'b1;
            end
          end else begin
            kern_q <= kern_q + 1'b1;
          end
        end
        default: ph <= PH_FRAME_OVH;
      endcase
    end
  end

  assign ovh_frame  = (ph == PH_FRAME_OVH);
  assign ovh_row    = (ph == PH_ROW_OVH);
  assign kernel_idx = kern_q;
  assign line_idx   = line_q;
endmodule

// File: rtl/fs_pulse.sv
module fs_pulse import fs_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       fire,
  input  logic [1:0] gran,
  output logic       active
);
  logic [PULSE_CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (fire) begin
      active <= 1'b1;
      cnt    <= PULSE_CW'(pulse_len(gran) - 1);
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/fs_integ.sv
module fs_integ import fs_pkg::*; #(
  parameter int LINES = 480,
  localparam int LW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slave_mode,
  input  logic [1:0]       gran,
  input  logic [REG_W-1:0] rel_line,
  input  logic [REG_W-1:0] dual_line,
  input  logic [REG_W-1:0] triple_line,
  input  logic             ext_pix_rst,
  input  logic             ext_dual,
  input  logic             ext_triple,
  input  logic             line_end,
  input  logic             frame_end,
  input  logic [LW-1:0]    line_idx,
  output logic             pix_rst,
  output logic             dual_pulse,
  output logic             triple_pulse,
  output logic             xfer_pulse
);
  localparam int NPULSE = 3;

  logic [REG_W-1:0]  cur_line;
  logic [NPULSE-1:0] fire;
  logic [NPULSE-1:0] busy;
  logic [2:0]        pin_q;
  logic              pr_q;

  assign cur_line = REG_W'(line_idx);
  assign fire[0]  = line_end && (cur_line == dual_line);
  assign fire[1]  = line_end && (cur_line == triple_line);
  assign fire[2]  = frame_end;

  for (genvar i = 0; i < NPULSE; i++) begin : g_pulse
    fs_pulse u_pulse (
      .clk   (clk),
      .rst   (rst),
      .fire  (fire[i]),
      .gran  (gran),
      .active(busy[i])
    );
  end

  // Frame end takes priority over the release match on the same line.
  always_ff @(posedge clk) begin
    if (rst)                                       pr_q <= 1'b1;
    else if (frame_end)                            pr_q <= 1'b1;
    else if (line_end && (cur_line == rel_line))   pr_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) pin_q <= '0;
    else     pin_q <= {ext_triple, ext_dual, ext_pix_rst};
  end

  assign pix_rst      = slave_mode ? pin_q[0] : pr_q;
  assign dual_pulse   = slave_mode ? pin_q[1] : busy[0];
  assign triple_pulse = slave_mode ? pin_q[2] : busy[1];
  assign xfer_pulse   = busy[2];
endmodule

// File: rtl/pix_frame_seq.sv
module pix_frame_seq import fs_pkg::*; #(
  parameter int LINES     = 480,
  parameter int KERNELS   = 160,
  parameter int ROW_OVH   = 16,
  parameter int FRAME_OVH = 16,
  parameter int CORE_DIV  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       slave_mode,
  input  logic [1:0]                 gran,
  input  logic [REG_W-1:0]           rel_line,
  input  logic [REG_W-1:0]           dual_line,
  input  logic [REG_W-1:0]           triple_line,
  input  logic [REG_W-1:0]           xfer_line,
  input  logic                       ext_pix_rst,
  input  logic                       ext_dual,
  input  logic                       ext_triple,
  output logic                       ovh_frame,
  output logic                       ovh_row,
  output logic [$clog2(KERNELS)-1:0] kernel_idx,
  output logic [$clog2(LINES)-1:0]   line_idx,
  output logic                       pix_rst,
  output logic                       dual_pulse,
  output logic                       triple_pulse,
  output logic                       xfer_pulse
);
  localparam int LW = $clog2(LINES);
  localparam int KW = $clog2(KERNELS);

  logic core_tick;
  logic line_end;
  logic frame_end;

  fs_clkdiv #(.DIV(CORE_DIV)) u_div (
    .clk (clk),
    .rst (rst),
    .tick(core_tick)
  );

  fs_readout #(
    .LINES(LINES), .KERNELS(KERNELS), .ROW_OVH(ROW_OVH), .FRAME_OVH(FRAME_OVH)
  ) u_rd (
    .clk       (clk),
    .rst       (rst),
    .tick      (core_tick),
    .xfer_line (xfer_line),
    .ovh_frame (ovh_frame),
    .ovh_row   (ovh_row),
    .kernel_idx(kernel_idx),
    .line_idx  (line_idx),
    .line_end  (line_end),
    .frame_end (frame_end)
  );

  fs_integ #(.LINES(LINES)) u_int (
    .clk         (clk),
    .rst         (rst),
    .slave_mode  (slave_mode),
    .gran        (gran),
    .rel_line    (rel_line),
    .dual_line   (dual_line),
    .triple_line (triple_line),
    .ext_pix_rst (ext_pix_rst),
    .ext_dual    (ext_dual),
    .ext_triple  (ext_triple),
    .line_end    (line_end),
    .frame_end   (frame_end),
    .line_idx    (line_idx),
    .pix_rst     (pix_rst),
    .dual_pulse  (dual_pulse),
    .triple_pulse(triple_pulse),
    .xfer_pulse  (xfer_pulse)
  );
endmodule

// File: rtl/fs_checker.sv
module fs_checker #(
  parameter int LINES   = 480,
  parameter int KERNELS = 160,
  parameter int LW      = 9,
  parameter int KW      = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          core_tick,
  input logic          slave_mode,
  input logic          ext_pix_rst,
  input logic          ext_dual,
  input logic          ext_triple,
  input logic          ovh_frame,
  input logic          ovh_row,
  input logic [KW-1:0] kernel_idx,
  input logic [LW-1:0] line_idx,
  input logic          pix_rst,
  input logic          dual_pulse,
  input logic          triple_pulse,
  input logic          xfer_pulse
);
  assert_idx_range_R10: assert property (@(posedge clk) disable iff (rst)
    (32'(kernel_idx) < KERNELS) && (32'(line_idx) < LINES));

  assert_phase_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(ovh_frame && ovh_row));

  assert_kern_step_R3: assert property (@(posedge clk) disable iff (rst)
    (core_tick && !ovh_frame && !ovh_row && (32'(kernel_idx) < KERNELS - 1))
    |=> (kernel_idx == KW'($past(kernel_idx) + 1'b1)));

  assert_hold_no_tick_R1: assert property (@(posedge clk) disable iff (rst)
    !core_tick |=> ($stable(kernel_idx) && $stable(line_idx) &&
                    $stable(ovh_frame) && $stable(ovh_row)));

  assert_xfer_opens_frame_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(xfer_pulse) |-> ($rose(ovh_frame) && (line_idx == '0)));

  assert_slave_follow_R9: assert property (@(posedge clk) disable iff (rst)
    (slave_mode && !$past(rst)) |->
      ((pix_rst == $past(ext_pix_rst)) && (dual_pulse == $past(ext_dual)) &&
       (triple_pulse == $past(ext_triple))));
endmodule

bind pix_frame_seq fs_checker #(
  .LINES(LINES), .KERNELS(KERNELS), .LW(LW), .KW(KW)
) u_fs_chk (
  .clk         (clk),
  .rst         (rst),
  .core_tick   (core_tick),
  .slave_mode  (slave_mode),
  .ext_pix_rst (ext_pix_rst),
  .ext_dual    (ext_dual),
  .ext_triple  (ext_triple),
  .ovh_frame   (ovh_frame),
  .ovh_row     (ovh_row),
  .kernel_idx  (kernel_idx),
  .line_idx    (line_idx),
  .pix_rst     (pix_rst),
  .dual_pulse  (dual_pulse),
  .triple_pulse(triple_pulse),
  .xfer_pulse  (xfer_pulse)
);

// File: tb/tb_pix_frame_seq.sv
module tb_pix_frame_seq;
  localparam int NL  = 10;
  localparam int NK  = 12;
  localparam int ROV = 4;
  localparam int FOV = 3;
  localparam int LW  = $clog2(NL);
  localparam int KW  = $clog2(NK);
  localparam int NRUN = 1000;
  localparam int NVEC = 6;

  // rel, dual, triple, xfer, gran, gran after first dual-slope rise
  localparam int VEC [0:NVEC-1][0:5] = '{
    '{2, 5, 7, 9, 0, 3},
    '{0, 1, 3, 6, 1, 1},
    '{4, 4, 8, 4, 0, 0},
    '{1, 3, 2, 20, 3, 3},
    '{9, 0, 9, 9, 2, 2},
    '{3, 6, 6, 7, 0, 0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slave_mode = 1'b0;
  logic [1:0] gran = 2'd0;
  logic [11:0] rel_line = '0, dual_line = '0, triple_line = '0, xfer_line = '0;
  logic ext_pix_rst = 1'b0, ext_dual = 1'b0, ext_triple = 1'b0;
  logic ovh_frame, ovh_row, pix_rst, dual_pulse, triple_pulse, xfer_pulse;
  logic [KW-1:0] kernel_idx;
  logic [LW-1:0] line_idx;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  int ds_rise, ds_w, ts_rise, ts_w, ft_rise, ft_w;
  int pr_fall, pr_rise, fot_again, rot_rise, rot_fall, max_line, max_kern;

  always #5 clk = ~clk;

  pix_frame_seq #(.LINES(NL), .KERNELS(NK), .ROW_OVH(ROV), .FRAME_OVH(FOV)) dut (
    .clk(clk), .rst(rst), .slave_mode(slave_mode), .gran(gran),
    .rel_line(rel_line), .dual_line(dual_line), .triple_line(triple_line),
    .xfer_line(xfer_line), .ext_pix_rst(ext_pix_rst), .ext_dual(ext_dual),
    .ext_triple(ext_triple), .ovh_frame(ovh_frame), .ovh_row(ovh_row),
    .kernel_idx(kernel_idx), .line_idx(line_idx), .pix_rst(pix_rst),
    .dual_pulse(dual_pulse), .triple_pulse(triple_pulse), .xfer_pulse(xfer_pulse)
  );

  function automatic int end_edge(input int n);
    return 4 * (FOV + (n + 1) * (ROV + NK));
  endfunction

  function automatic int width_of(input int g);
    return 4 * (12 * (g + 1) + 1);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic hold_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic measure(input int g_after);
    bit ds_p = 1'b0, ts_p = 1'b0, ft_p = 1'b0, pr_p = 1'b1, fot_p = 1'b1, rot_p = 1'b0;
    bit ds_d = 1'b0, ts_d = 1'b0, ft_d = 1'b0;
    ds_rise = 0; ds_w = 0; ts_rise = 0; ts_w = 0; ft_rise = 0; ft_w = 0;
    pr_fall = 0; pr_rise = 0; fot_again = 0; rot_rise = 0; rot_fall = 0;
    max_line = 0; max_kern = 0;
    for (int e = 1; e <= NRUN; e++) begin
      @(posedge clk);
      #1;
      if (dual_pulse && !ds_p && ds_rise == 0) begin
        ds_rise = e;
        if (g_after >= 0) gran = 2'(g_after);
      end
      if (ds_rise != 0 && !ds_d) begin if (dual_pulse) ds_w++; else ds_d = 1'b1; end
      if (triple_pulse && !ts_p && ts_rise == 0) ts_rise = e;
      if (ts_rise != 0 && !ts_d) begin if (triple_pulse) ts_w++; else ts_d = 1'b1; end
      if (xfer_pulse && !ft_p && ft_rise == 0) ft_rise = e;
      if (ft_rise != 0 && !ft_d) begin if (xfer_pulse) ft_w++; else ft_d = 1'b1; end
      if (pr_p && !pix_rst && pr_fall == 0) pr_fall = e;
      if (!pr_p && pix_rst && pr_fall != 0 && pr_rise == 0) pr_rise = e;
      if (ovh_frame && !fot_p && fot_again == 0) fot_again = e;
      if (ovh_row && !rot_p && rot_rise == 0) rot_rise = e;
      if (!ovh_row && rot_p && rot_fall == 0) rot_fall = e;
      if (fot_again == 0) begin
        if (32'(line_idx) > max_line) max_line = 32'(line_idx);
        if (32'(kernel_idx) > max_kern) max_kern = 32'(kernel_idx);
      end
      ds_p = dual_pulse; ts_p = triple_pulse; ft_p = xfer_pulse;
      pr_p = pix_rst; fot_p = ovh_frame; rot_p = ovh_row;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog R1: actual=timeout expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // Reset state (R2)
    hold_reset();
    chk("R2", "ovh_frame in reset", 32'(ovh_frame), 1);
    chk("R2", "ovh_row in reset", 32'(ovh_row), 0);
    chk("R2", "kernel_idx in reset", 32'(kernel_idx), 0);
    chk("R2", "line_idx in reset", 32'(line_idx), 0);
    chk("R2", "pix_rst in reset", 32'(pix_rst), 1);
    chk("R2", "pulses in reset", 32'({dual_pulse, triple_pulse, xfer_pulse}), 0);

    // Vector table walk in master mode
    for (int v = 0; v < NVEC; v++) begin
      int fe, g0, g1, eg;
      rel_line = 12'(VEC[v][0]); dual_line = 12'(VEC[v][1]);
      triple_line = 12'(VEC[v][2]); xfer_line = 12'(VEC[v][3]);
      g0 = VEC[v][4]; g1 = VEC[v][5];
      gran = 2'(g0);
      slave_mode = 1'b0;
      fe = (VEC[v][3] < NL - 1) ? VEC[v][3] : NL - 1;
      hold_reset();
      release_reset();
      measure(g1);
      $display("vector %0d", v);
      chk("R1", "row phase start edge", rot_rise, 4 * FOV);
      chk("R3", "row phase end edge", rot_fall, 4 * (FOV + ROV));
      chk("R10", "max line in frame", max_line, fe);
      chk("R3", "max kernel", max_kern, NK - 1);
      chk("R4", "transfer rise edge", ft_rise, end_edge(fe));
      chk("R4", "frame overhead restart edge", fot_again, end_edge(fe));
      eg = (ds_rise != 0 && ft_rise > ds_rise) ? g1 : g0;
      chk("R6", "transfer width", ft_w, width_of(eg));
      if (VEC[v][1] <= fe) begin
        chk("R8", "dual rise edge", ds_rise, end_edge(VEC[v][1]));
        chk("R6", "dual width", ds_w, width_of(g0));
      end else begin
        chk("R5", "dual never fires", ds_rise, 0);
      end
      if (VEC[v][2] <= fe) begin
        eg = (ds_rise != 0 && ts_rise > ds_rise) ? g1 : g0;
        chk("R8", "triple rise edge", ts_rise, end_edge(VEC[v][2]));
        chk("R6", "triple width", ts_w, width_of(eg));
      end else begin
        chk("R5", "triple never fires", ts_rise, 0);
      end
      if (VEC[v][0] < fe) begin
        chk("R7", "pix_rst fall edge", pr_fall, end_edge(VEC[v][0]));
        chk("R7", "pix_rst rise at frame end", pr_rise, end_edge(fe));
      end else begin
        chk("R7", "pix_rst held (frame end wins)", pr_fall, 0);
      end
    end

    // Slave mode: pins drive integration outputs, readout unchanged (R9)
    rel_line = 12'd2; dual_line = 12'd5; triple_line = 12'd7; xfer_line = 12'd9;
    gran = 2'd0;
    slave_mode = 1'b1;
    ext_pix_rst = 1'b0; ext_dual = 1'b0; ext_triple = 1'b0;
    hold_reset();
    release_reset();
    measure(-1);
    chk("R9", "slave dual ignores target", ds_rise, 0);
    chk("R9", "slave triple ignores target", ts_rise, 0);
    chk("R9", "slave transfer rise edge", ft_rise, end_edge(9));
    chk("R9", "slave row phase start", rot_rise, 4 * FOV);

    @(negedge clk);
    ext_pix_rst = 1'b1; ext_dual = 1'b0; ext_triple = 1'b1;
    @(posedge clk); #1;
    chk("R9", "slave outputs after 101", 32'({triple_pulse, dual_pulse, pix_rst}), 3'b101);
    @(negedge clk);
    ext_pix_rst = 1'b0; ext_dual = 1'b1; ext_triple = 1'b0;
    #1;
    chk("R9", "slave outputs before edge", 32'({triple_pulse, dual_pulse, pix_rst}), 3'b101);
    @(posedge clk); #1;
    chk("R9", "slave outputs after 010", 32'({triple_pulse, dual_pulse, pix_rst}), 3'b010);

    // Back to master mid-frame: pixel reset state and idle pulses return
    @(negedge clk);
    slave_mode = 1'b0;
    #1;
    chk("R7", "master dual idle after switch", 32'(dual_pulse), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule